// File: doc/BRIEF.md
# SPI ADC Command Sequencer

This block drives an eight-channel, 16-bit successive-approximation converter over a four-wire SPI link. A local client hands it one request at a time. A request can reset the converter, set the input range of one channel, or convert one channel and return the 16-bit code. The block builds the serial frames, generates the serial clock, MOSI and an active-low chip select, and shifts in MISO.

Requests enter on a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A client may hold `req_valid` with stable fields for as long as it likes, and the request is taken on the first clock edge where both signals are high. The response side has no back-pressure: `rsp_done` pulses for one cycle, and `rsp_err` and `rsp_data` are valid in that cycle. Requests with bad fields are answered on the cycle after acceptance and put nothing on the wire. After reset the sequencer sends a reset command to the converter by itself, and only then raises `req_ready`.

Opcodes on `req_op`: 0 resets the converter, 1 programs a channel range, 2 converts a channel, and 3 is reserved.

Top module: `adcseq_top`

## Requirements
- R1: After reset, `req_ready` stays low until one 32-bit frame 0x85000000 has been sent on its own.
- R2: A reset request (op 0) sends one 32-bit command frame: code 0x85 in bits 31:24 and all other bits zero. It is answered with `rsp_err`=0 and `rsp_data`=0.
- R3: A range request (op 1) sends one 24-bit frame built as follows. Bits 23:17 carry address 0x05 plus the channel. Bit 16 is 1. Bits 15:8 carry the range code from `req_code`. Bits 7:0 are zero. The response has `rsp_err`=0 and `rsp_data`=0.
- R4: Range codes other than 0, 1, 2, 5 and 6 are answered with `rsp_err`=1 and `rsp_data`=0, and no frame is sent.
- R5: A conversion request (op 2) sends two frames. The first is a 32-bit command with code 0xC0 plus four times the channel in bits 31:24. Chip select then rises, and a 32-bit frame of all zeros (no-op) follows. `rsp_data` returns the last 16 bits received during the second frame.
- R6: A range or conversion request naming a channel at or above `NUM_CH` is answered with `rsp_err`=1 and no frame is sent.
- R7: Opcode 3 is answered with `rsp_err`=1 and no frame is sent.
- R8: The serial clock idles low while chip select is high. MOSI changes only on rising clock edges and is sent most significant bit first. MISO is sampled on falling edges.
- R9: Between any two frames, chip select stays high for at least 2*`DIV` system clock cycles (two serial clock periods).
- R10: `req_ready` is low while a frame is in progress. Every accepted request gets exactly one `rsp_done` pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 2 | Opcode: 0 reset, 1 range, 2 convert, 3 reserved |
| req_chan | input | 3 | Channel number |
| req_code | input | 8 | Range code for op 1 |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request rejected; valid with `rsp_done` |
| rsp_data | output | 16 | Conversion result; valid with `rsp_done` |
| spi_sclk | output | 1 | Serial clock, mode 1 |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the converter |
| spi_miso | input | 1 | Serial data from the converter |

## Verification
The bound checker watches the link and the handshake on every cycle. It checks that the clock stays low with chip select high and that MOSI holds across falling edges. It also checks the minimum chip-select high time between frames, that no request is taken mid-frame, that `rsp_done` is a single-cycle pulse, and that error responses carry zero data. Other behaviour shows only in the bench scenarios, where a behavioural converter model captures whole frames and returns per-channel results:
- the exact frame contents and lengths;
- the boot reset frame;
- the two-frame read with its result taken from the second frame;
- the rule that rejected requests put nothing on the wire.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [1:0] {
    OP_RESET   = 2'd0,
    OP_RANGE   = 2'd1,
    OP_CONVERT = 2'd2,
    OP_RSVD    = 2'd3
  } adc_op_e;

  typedef enum logic {
    FK_CMD  = 1'b0,
    FK_PROG = 1'b1
  } frame_kind_e;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned LEN_W    = 6;
  localparam int unsigned CMD_LEN  = 32;
  localparam int unsigned PROG_LEN = 24;
  localparam int unsigned RESULT_W = 16;

  localparam logic [7:0] CODE_RESET = 8'h85;
  localparam logic [7:0] CODE_NOOP  = 8'h00;
  localparam logic [7:0] CODE_CHSEL = 8'hC0;
  localparam logic [6:0] ADDR_RANGE = 7'h05;

  function automatic logic range_code_legal(input logic [7:0] c);
    return (c == 8'd0) || (c == 8'd1) || (c == 8'd2) || (c == 8'd5) || (c == 8'd6);
  endfunction

endpackage

// File: rtl/adcseq_frame.sv
module adcseq_frame
  import adcseq_pkg::*;
(
  input  frame_kind_e        kind,
  input  logic [7:0]         cmd_code,
  input  logic [6:0]         reg_addr,
  input  logic [7:0]         reg_val,
  output logic [WORD_W-1:0]  word,
  output logic [LEN_W-1:0]   nbits
);
  // Frames are left-aligned: the first bit on the wire is word[WORD_W-1].
  always_comb begin
    if (kind == FK_PROG) begin
      word  = {reg_addr, 1'b1, reg_val, 8'h00, 8'h00};
      nbits = LEN_W'(PROG_LEN);
    end else begin
      word  = {cmd_code, 8'h00, 16'h0000};
      nbits = LEN_W'(CMD_LEN);
    end
  end
endmodule

// File: rtl/adcseq_reqcheck.sv
module adcseq_reqcheck
  import adcseq_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic [1:0] op,
  input  logic [2:0] chan,
  input  logic [7:0] code,
  output logic       legal
);
  logic chan_ok;

  generate
    if (NUM_CH >= 8) begin : g_full
      assign chan_ok = 1'b1;
    end else begin : g_part
      assign chan_ok = ({1'b0, chan} < 4'(NUM_CH));
    end
  endgenerate

  always_comb begin
    unique case (adc_op_e'(op))
      OP_RESET:   legal = 1'b1;
      OP_RANGE:   legal = chan_ok && range_code_legal(code);
      OP_CONVERT: legal = chan_ok;
      default:    legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/adcseq_spi_engine.sv
module adcseq_spi_engine
  import adcseq_pkg::*;
#(
  parameter int unsigned DIV = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WORD_W-1:0]  tx_word,
  input  logic [LEN_W-1:0]   tx_len,
  output logic [WORD_W-1:0]  rx_word,
  output logic               done,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi,
  input  logic               miso
);
  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned GAP  = 2 * DIV;
  localparam int unsigned CW   = $clog2(GAP + 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);
  localparam logic [CW-1:0] GAP_LAST  = CW'(GAP - 1);

  typedef enum logic [2:0] {E_IDLE, E_LEAD, E_HIGH, E_LOW, E_TAIL, E_GAP} eng_st_e;

  eng_st_e             st;
  logic [CW-1:0]       cnt;
  logic [LEN_W-1:0]    left;
  logic [WORD_W-1:0]   sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= E_IDLE;
      cnt     <= '0;
      left    <= '0;
      sh      <= '0;
      rx_word <= '0;
      done    <= 1'b0;
      sclk    <= 1'b0;
      cs_n    <= 1'b1;
      mosi    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        E_IDLE: begin
          if (start) begin
            sh      <= tx_word;
            left    <= tx_len;
            rx_word <= '0;
            cnt     <= '0;
            cs_n    <= 1'b0;
            st      <= E_LEAD;
          end
        end
        E_LEAD, E_LOW: begin
          if (cnt == HALF_LAST) begin
            cnt  <= '0;
            sclk <= 1'b1;
            mosi <= sh[WORD_W-1];
            sh   <= {sh[WORD_W-2:0], 1'b0};
            st   <= E_HIGH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        E_HIGH: begin
          if (cnt == HALF_LAST) begin
            cnt     <= '0;
            sclk    <= 1'b0;
            rx_word <= {rx_word[WORD_W-2:0], miso};
            left    <= left - 1'b1;
            st      <= (left == LEN_W'(1)) ? E_TAIL : E_LOW;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        E_TAIL: begin
          if (cnt == HALF_LAST) begin
            cnt  <= '0;
            cs_n <= 1'b1;
            mosi <= 1'b0;
            st   <= E_GAP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        E_GAP: begin
          if (cnt == GAP_LAST) begin
            cnt  <= '0;
            done <= 1'b1;
            st   <= E_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
  import adcseq_pkg::*;
#(
  parameter int unsigned DIV    = 4,
  parameter int unsigned NUM_CH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_op,
  input  logic [2:0]  req_chan,
  input  logic [7:0]  req_code,
  output logic        rsp_done,
  output logic        rsp_err,
  output logic [15:0] rsp_data,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  typedef enum logic [2:0] {T_BOOT, T_BOOTW, T_IDLE, T_F1, T_F2} top_st_e;

  top_st_e            st;
  adc_op_e            op_q;
  logic               start_q;
  logic [WORD_W-1:0]  tx_q;
  logic [LEN_W-1:0]   len_q;

  logic               req_legal;
  frame_kind_e        f_kind;
  logic [7:0]         f_code;
  logic [6:0]         f_addr;
  logic [WORD_W-1:0]  f_word;
  logic [LEN_W-1:0]   f_len;
  logic [WORD_W-1:0]  eng_rx;
  logic               eng_done;

  adcseq_reqcheck #(.NUM_CH(NUM_CH)) u_chk_req (
    .op    (req_op),
    .chan  (req_chan),
    .code  (req_code),
    .legal (req_legal)
  );

  // Select the next frame to issue from the current state or the pending request.
  always_comb begin
    f_kind = FK_CMD;
    f_code = CODE_RESET;
    f_addr = ADDR_RANGE + {4'b0000, req_chan};
    if (st == T_F1) begin
      f_code = CODE_NOOP;
    end else if (st == T_IDLE) begin
      unique case (adc_op_e'(req_op))
        OP_RANGE:   f_kind = FK_PROG;
        OP_CONVERT: f_code = CODE_CHSEL + {3'b000, req_chan, 2'b00};
        default:    f_code = CODE_RESET;
      endcase
    end
  end

  adcseq_frame u_frame (
    .kind     (f_kind),
    .cmd_code (f_code),
    .reg_addr (f_addr),
    .reg_val  (req_code),
    .word     (f_word),
    .nbits    (f_len)
  );

  adcseq_spi_engine #(.DIV(DIV)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_q),
    .tx_word (tx_q),
    .tx_len  (len_q),
    .rx_word (eng_rx),
    .done    (eng_done),
    .sclk    (spi_sclk),
    .cs_n    (spi_cs_n),
    .mosi    (spi_mosi),
    .miso    (spi_miso)
  );

  assign req_ready = (st == T_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= T_BOOT;
      op_q     <= OP_RESET;
      start_q  <= 1'b0;
      tx_q     <= '0;
      len_q    <= '0;
      rsp_done <= 1'b0;
      rsp_err  <= 1'b0;
      rsp_data <= '0;
    end else begin
      start_q  <= 1'b0;
      rsp_done <= 1'b0;
      unique case (st)
        T_BOOT: begin
          start_q <= 1'b1;
          tx_q    <= f_word;
          len_q   <= f_len;
          st      <= T_BOOTW;
        end
        T_BOOTW: begin
          if (eng_done) st <= T_IDLE;
        end
        T_IDLE: begin
          if (req_valid) begin
            if (!req_legal) begin
              rsp_done <= 1'b1;
              rsp_err  <= 1'b1;
              rsp_data <= '0;
            end else begin
              start_q <= 1'b1;
              tx_q    <= f_word;
              len_q   <= f_len;
              op_q    <= adc_op_e'(req_op);
              st      <= T_F1;
            end
          end
        end
        T_F1: begin
          if (eng_done) begin
            if (op_q == OP_CONVERT) begin
              start_q <= 1'b1;
              tx_q    <= f_word;
              len_q   <= f_len;
              st      <= T_F2;
            end else begin
              rsp_done <= 1'b1;
              rsp_err  <= 1'b0;
              rsp_data <= '0;
              st       <= T_IDLE;
            end
          end
        end
        T_F2: begin
          if (eng_done) begin
            rsp_done <= 1'b1;
            rsp_err  <= 1'b0;
            rsp_data <= eng_rx[RESULT_W-1:0];
            st       <= T_IDLE;
          end
        end
        default: st <= T_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adcseq_checker.sv
module adcseq_checker #(
  parameter int unsigned DIV = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_done,
  input logic        rsp_err,
  input logic [15:0] rsp_data,
  input logic        spi_sclk,
  input logic        spi_cs_n,
  input logic        spi_mosi
);
  localparam int unsigned GAP = 2 * DIV;
  localparam int unsigned GW  = $clog2(GAP + 2);
  localparam logic [GW-1:0] GAP_SAT = GW'(GAP);

  logic [GW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            hi_cnt <= GAP_SAT;
    else if (!spi_cs_n)    hi_cnt <= '0;
    else if (hi_cnt != GAP_SAT) hi_cnt <= hi_cnt + 1'b1;
  end

  p_sclk_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  p_mosi_hold_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_sclk) |-> $stable(spi_mosi));

  p_cs_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (hi_cnt >= GAP_SAT));

  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> !req_ready);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_err_zero_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_err) |-> (rsp_data == 16'h0000));
endmodule

bind adcseq_top adcseq_checker #(.DIV(DIV)) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .rsp_err   (rsp_err),
  .rsp_data  (rsp_data),
  .spi_sclk  (spi_sclk),
  .spi_cs_n  (spi_cs_n),
  .spi_mosi  (spi_mosi)
);

// File: tb/sim_adcseq_top.sv
module sim_adcseq_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int NUM_CH     = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic [2:0]  req_chan = '0;
  logic [7:0]  req_code = '0;
  logic        rsp_done, rsp_err;
  logic [15:0] rsp_data;
  logic        spi_sclk, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [37:0] exp_frames[$];
  string       exp_ftags[$];
  logic [16:0] exp_resp[$];
  string       exp_rtags[$];
  logic [15:0] chan_val[8];

  always #(CLK_PERIOD/2) clk = ~clk;

  adcseq_top #(.DIV(DIV), .NUM_CH(NUM_CH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_chan(req_chan), .req_code(req_code),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Behavioural converter: captures MOSI on falling edges, drives MISO on rising edges.
  logic [31:0] s_rx;
  logic [31:0] s_tx;
  int          s_bits;
  logic        s_chsel_seen = 1'b0;
  logic [2:0]  s_chsel_ch = '0;

  always @(negedge spi_cs_n) begin
    s_rx   = '0;
    s_bits = 0;
    s_tx   = s_chsel_seen ? {16'h5A5A, chan_val[s_chsel_ch]} : 32'hDEADBEEF;
  end

  always @(posedge spi_sclk) begin
    spi_miso = s_tx[31];
    s_tx     = {s_tx[30:0], 1'b0};
  end

  always @(negedge spi_sclk) begin
    s_rx   = {s_rx[30:0], spi_mosi};
    s_bits = s_bits + 1;
  end

  always @(posedge spi_cs_n) begin
    if (rst_n) begin
      if (exp_frames.size() == 0) begin
        checks++; fails++;
        $display("FAIL R4/R6/R7: actual unexpected frame %0h expected no frame", s_rx);
      end else begin
        logic [37:0] e;
        string t;
        e = exp_frames.pop_front();
        t = exp_ftags.pop_front();
        check(t, {26'b0, 6'(s_bits), s_rx}, {26'b0, e});
      end
      s_chsel_seen = (s_bits == 32) && (s_rx[31:29] == 3'b110) &&
                     (s_rx[25:24] == 2'b00) && (s_rx[23:0] == 24'h0);
      s_chsel_ch   = s_rx[28:26];
    end
  end

  // Response monitor (scoreboard pop side)
  always @(negedge clk) begin
    if (rst_n && rsp_done) begin
      if (exp_resp.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10: actual unexpected response expected none");
      end else begin
        logic [16:0] e;
        string t;
        e = exp_resp.pop_front();
        t = exp_rtags.pop_front();
        check(t, {47'b0, rsp_err, rsp_data}, {47'b0, e});
      end
    end
  end

  // Chip-select high-time monitor
  int hi_cycles = 1000;
  logic cs_prev = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_prev && !spi_cs_n) check("R9 cs gap", 64'(hi_cycles >= 2*DIV), 64'd1);
      if (spi_cs_n) hi_cycles++; else hi_cycles = 0;
    end
    cs_prev = spi_cs_n;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  task automatic push_frame(string tag, int len, logic [31:0] w);
    exp_frames.push_back({6'(len), w});
    exp_ftags.push_back(tag);
  endtask

  task automatic issue(logic [1:0] op, logic [2:0] ch, logic [7:0] code, logic [15:0] val);
    logic bad;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    bad = (op == 2'd3) ||
          ((op != 2'd0) && (int'(ch) >= NUM_CH)) ||
          ((op == 2'd1) && !(code inside {8'd0, 8'd1, 8'd2, 8'd5, 8'd6}));
    if (bad) begin
      exp_resp.push_back({1'b1, 16'h0});
      exp_rtags.push_back(op == 2'd3 ? "R7 reserved op" :
                          (int'(ch) >= NUM_CH ? "R6 channel limit" : "R4 bad range code"));
    end else if (op == 2'd0) begin
      push_frame("R2 reset frame", 32, 32'h8500_0000);
      exp_resp.push_back({1'b0, 16'h0});
      exp_rtags.push_back("R2 reset response");
    end else if (op == 2'd1) begin
      push_frame("R3 range frame", 24, {8'h00, 7'(7'h05 + 7'(ch)), 1'b1, code, 8'h00});
      exp_resp.push_back({1'b0, 16'h0});
      exp_rtags.push_back("R3 range response");
    end else begin
      chan_val[ch] = val;
      push_frame("R5 select frame", 32, {8'(8'hC0 + 8'(ch) * 8'd4), 24'h0});
      push_frame("R5 noop frame", 32, 32'h0);
      exp_resp.push_back({1'b0, val});
      exp_rtags.push_back("R5 read result");
    end
    req_op = op; req_chan = ch; req_code = code; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_resp.size() != 0 || exp_frames.size() != 0) && n < 5000) begin
      @(negedge clk); n++;
    end
    repeat (20) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) chan_val[i] = 16'h0;
    repeat (3) @(negedge clk);
    check("R1 reset cs_n",   64'(spi_cs_n),  64'd1);
    check("R8 reset sclk",   64'(spi_sclk),  64'd0);
    check("R10 reset ready", 64'(req_ready), 64'd0);
    check("R10 reset done",  64'(rsp_done),  64'd0);
    push_frame("R1 boot frame", 32, 32'h8500_0000);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    check("R1 ready low during boot", 64'(req_ready), 64'd0);
    check("R1 boot frame active", 64'(spi_cs_n), 64'd0);
    drain();
    check("R1 ready after boot", 64'(req_ready), 64'd1);

    issue(2'd2, 3'd0, 8'd0, 16'h1234);
    issue(2'd2, 3'd3, 8'd0, 16'hFFFF);
    issue(2'd2, 3'd2, 8'd0, 16'h0000);
    issue(2'd2, 3'd1, 8'd0, 16'h8001);
    drain();
    issue(2'd1, 3'd0, 8'd0, 16'h0);
    issue(2'd1, 3'd1, 8'd1, 16'h0);
    issue(2'd1, 3'd2, 8'd2, 16'h0);
    issue(2'd1, 3'd3, 8'd5, 16'h0);
    issue(2'd1, 3'd0, 8'd6, 16'h0);
    drain();
    issue(2'd1, 3'd0, 8'd3, 16'h0);
    issue(2'd1, 3'd1, 8'd4, 16'h0);
    issue(2'd1, 3'd2, 8'd7, 16'h0);
    issue(2'd1, 3'd3, 8'hFF, 16'h0);
    drain();
    check("R4 no frame on bad code", 64'(spi_cs_n), 64'd1);
    issue(2'd1, 3'd5, 8'd1, 16'h0);
    issue(2'd2, 3'd4, 8'd0, 16'hAAAA);
    issue(2'd2, 3'd7, 8'd0, 16'hBBBB);
    issue(2'd3, 3'd0, 8'd0, 16'h0);
    drain();
    check("R6 R7 no frame queued", 64'(exp_frames.size()), 64'd0);
    issue(2'd0, 3'd0, 8'd0, 16'h0);
    issue(2'd2, 3'd1, 8'd0, 16'hC3A5);
    drain();
    check("R10 all responses seen", 64'(exp_resp.size()), 64'd0);
    check("R5 all frames seen", 64'(exp_frames.size()), 64'd0);
    finish_run();
  end
endmodule